// File: doc/BRIEF.md
# Interleaved Memory Address Decoder Bank

A bank of host-address decoders for a memory expander or switch port. Each decoder holds a host window (base and byte size), a way count, a block granularity, an ordered list of downstream port ids and a device-address base. A host address looked up against the bank hits the lowest-index decoder whose committed window claims it. The result names that decoder, the port id picked by rotating through the list one granularity block at a time, and a device-local address in which the blocks sent to one port are packed back to back.

All configuration goes through one register-write port, selected by decoder index and field code. The commit and lock controls use the same port. Decoders must be committed in ascending index order and released in descending order. A committed decoder's range settings are frozen. A lock pins a committed decoder until reset. A per-decoder mode query reports whether the decoder's device range sits below, above or across the volatile capacity boundary.

Top module: `interleave_decode_bank`

## Requirements
- R1: After reset no decoder is committed, every mode reads none (0), commit_ack_o and commit_err_o are low, and no lookup hits.
- R2: A lookup hits only when some committed decoder has base <= address < base + size. The window end is exclusive.
- R3: The selected port id is list slot ((address - base) / granularity) mod ways. Ways come from a 3-bit code e (ways = 2^e, codes 0..3 legal). Granularity comes from a 3-bit code g (granularity = 256 << g, codes 0..6 legal).
- R4: The device address is device base + ((address - base) / granularity / ways) * granularity + (address - base) mod granularity.
- R5: When several committed decoders claim an address, the lowest index wins and is reported on dec_o.
- R6: Lookup results are registered. lk_valid_o, hit_o, dec_o, tgt_o and dpa_o reflect the request presented in the previous cycle, and lk_valid_o is low the cycle after no request.
- R7: A commit write uses field 6 with data bit 0 = 1. It is accepted only for the decoder whose index equals the number of committed decoders. An accepted commit pulses commit_ack_o for one cycle in the cycle after the write. Any refused commit or release pulses commit_err_o in that cycle instead.
- R8: A commit of a decoder whose way code is above 3 or whose granularity code is 7 is refused with commit_err_o.
- R9: Field writes are ignored while the target decoder is committed. The field codes are: 0 base, 1 size, 2 device base, 3 way code (data[2:0]), 4 granularity code (data[2:0]), and 5 list slot. For field 5, data[18:16] is the slot and data[3:0] is the port id.
- R10: A lock write uses field 7 with data bit 0 = 1. On a committed decoder it prevents that decoder's release until reset, and the decoder keeps decoding. On an uncommitted decoder the lock write is ignored.
- R11: A release write uses field 6 with data bit 0 = 0. It is accepted only for the highest-index committed decoder that is not locked.
- R12: mode_o for the decoder on mode_sel_i reads as follows. It reads 0 (none) when the decoder is not committed. Otherwise let span = size / ways. It reads 1 (volatile) when device base + span <= VOL_CAP. It reads 2 (persistent) when device base >= VOL_CAP. In all other cases it reads 3 (mixed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | IDX_W | Decoder addressed by the write |
| wr_field_i | input | 4 | Field code |
| wr_data_i | input | DATA_W | Write data |
| commit_ack_o | output | 1 | Accepted commit or release pulse |
| commit_err_o | output | 1 | Refused commit or release pulse |
| mode_sel_i | input | IDX_W | Decoder whose mode is reported |
| mode_o | output | 2 | Mode of the selected decoder |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | HPA_W | Host address to decode |
| lk_valid_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | Address claimed by a committed decoder |
| dec_o | output | IDX_W | Winning decoder index |
| tgt_o | output | TGT_W | Selected downstream port id |
| dpa_o | output | DPA_W | Device-local address |

## Verification
The bench walks every legal pair of way code and granularity code on one decoder. For each pair it probes addresses on an odd stride that crosses many block boundaries, plus the four addresses that sit on either side of the window ends. The odd stride exposes wrong slot selection and wrong packing of rows. The end probes separate inclusive from exclusive limits. Overlapping windows committed on two decoders show which index takes priority. Out-of-order commits, releases, locks and writes to frozen decoders are each followed by a lookup or a mode read, so a write that slipped through shows up at the outputs. Three device-range placements against the volatile boundary, plus an idle decoder, cover every mode value.

// File: rtl/ild_pkg.sv
package ild_pkg;
  localparam int unsigned MAX_WAYS     = 8;
  localparam int unsigned SLOT_W       = 3;
  localparam int unsigned SLOT_LSB     = 16;
  localparam int unsigned GRAN_MIN_LOG = 8;

  typedef enum logic [3:0] {
    F_BASE   = 4'd0,
    F_SIZE   = 4'd1,
    F_DPA    = 4'd2,
    F_WAYS   = 4'd3,
    F_GRAN   = 4'd4,
    F_TGT    = 4'd5,
    F_COMMIT = 4'd6,
    F_LOCK   = 4'd7
  } field_e;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'd0,
    MODE_VOL   = 2'd1,
    MODE_PERS  = 2'd2,
    MODE_MIXED = 2'd3
  } mode_e;

  function automatic logic ways_code_ok(input logic [2:0] code);
    return code <= 3'd3;
  endfunction

  function automatic logic gran_code_ok(input logic [2:0] code);
    return code <= 3'd6;
  endfunction
endpackage

// File: rtl/idb_cfg_regs.sv
module idb_cfg_regs
  import ild_pkg::*;
#(
  parameter int unsigned HPA_W  = 32,
  parameter int unsigned DPA_W  = 32,
  parameter int unsigned TGT_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 we_i,
  input  logic [3:0]                           field_i,
  input  logic [DATA_W-1:0]                    data_i,
  input  logic                                 frozen_i,
  output logic [HPA_W-1:0]                     base_o,
  output logic [HPA_W-1:0]                     size_o,
  output logic [DPA_W-1:0]                     dpa_base_o,
  output logic [2:0]                           ways_enc_o,
  output logic [2:0]                           gran_enc_o,
  output logic [MAX_WAYS-1:0][TGT_W-1:0]       tgt_list_o
);
  logic [SLOT_W-1:0] slot;
  assign slot = data_i[SLOT_LSB +: SLOT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o     <= '0;
      size_o     <= '0;
      dpa_base_o <= '0;
      ways_enc_o <= '0;
      gran_enc_o <= '0;
      tgt_list_o <= '0;
    end else if (we_i && !frozen_i) begin
      case (field_e'(field_i))
        F_BASE: base_o     <= HPA_W'(data_i);
        F_SIZE: size_o     <= HPA_W'(data_i);
        F_DPA:  dpa_base_o <= DPA_W'(data_i);
        F_WAYS: ways_enc_o <= data_i[2:0];
        F_GRAN: gran_enc_o <= data_i[2:0];
        F_TGT:  tgt_list_o[slot] <= data_i[TGT_W-1:0];
        default: ;
      endcase
    end
  end

  assert_cfg_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frozen_i) |-> ($stable(base_o) && $stable(size_o) && $stable(dpa_base_o)
                         && $stable(ways_enc_o) && $stable(gran_enc_o) && $stable(tgt_list_o)));
endmodule

// File: rtl/idb_commit_ctrl.sv
module idb_commit_ctrl #(
  parameter int unsigned NUM_DEC = 4,
  localparam int unsigned IDX_W  = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1,
  localparam int unsigned CNT_W  = $clog2(NUM_DEC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_commit_i,
  input  logic               cmd_lock_i,
  input  logic               cmd_set_i,
  input  logic [IDX_W-1:0]   cmd_idx_i,
  input  logic               enc_ok_i,
  output logic [NUM_DEC-1:0] committed_o,
  output logic [NUM_DEC-1:0] locked_o,
  output logic               ack_o,
  output logic               err_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             is_next, is_last, commit_ok, release_ok, lock_ok;

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_comm
    assign committed_o[i] = CNT_W'(i) < cnt_q;
  end

  assign is_next    = CNT_W'(cmd_idx_i) == cnt_q;
  assign is_last    = (cnt_q != '0) && (CNT_W'(cmd_idx_i) == cnt_q - CNT_W'(1));
  assign commit_ok  = cmd_commit_i && cmd_set_i && is_next && enc_ok_i;
  assign release_ok = cmd_commit_i && !cmd_set_i && is_last && !locked_o[cmd_idx_i];
  assign lock_ok    = cmd_lock_i && cmd_set_i && committed_o[cmd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      locked_o <= '0;
      ack_o    <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      ack_o <= commit_ok || release_ok;
      err_o <= cmd_commit_i && !(commit_ok || release_ok);
      if (commit_ok)       cnt_q <= cnt_q + CNT_W'(1);
      else if (release_ok) cnt_q <= cnt_q - CNT_W'(1);
      if (lock_ok) locked_o[cmd_idx_i] <= 1'b1;
    end
  end

  assert_cnt_moves_with_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> ack_o);
  assert_ack_err_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && err_o));
  assert_lock_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(locked_o) & ~locked_o) == '0);
  assert_lock_needs_commit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o & ~committed_o) == '0);
endmodule

// File: rtl/idb_window_match.sv
module idb_window_match
  import ild_pkg::*;
#(
  parameter int unsigned HPA_W   = 32,
  parameter int unsigned DPA_W   = 32,
  parameter int unsigned TGT_W   = 4,
  parameter logic [63:0] VOL_CAP = 64'h4000_0000
) (
  input  logic [HPA_W-1:0]               addr_i,
  input  logic                           committed_i,
  input  logic [HPA_W-1:0]               base_i,
  input  logic [HPA_W-1:0]               size_i,
  input  logic [DPA_W-1:0]               dpa_base_i,
  input  logic [2:0]                     ways_enc_i,
  input  logic [2:0]                     gran_enc_i,
  input  logic [MAX_WAYS-1:0][TGT_W-1:0] tgt_list_i,
  output logic                           match_o,
  output logic [TGT_W-1:0]               tgt_o,
  output logic [DPA_W-1:0]               dpa_o,
  output mode_e                          mode_o
);
  localparam logic [DPA_W:0] VCAP = (DPA_W+1)'(VOL_CAP);

  logic [HPA_W-1:0]  offset, block, row, gmask, dev_off, span;
  logic [4:0]        gshift;
  logic [SLOT_W-1:0] wmask, slot;
  logic [DPA_W:0]    dpa_end;

  assign offset  = addr_i - base_i;
  assign match_o = committed_i && (addr_i >= base_i) && (offset < size_i);
  assign gshift  = 5'(GRAN_MIN_LOG) + {2'b00, gran_enc_i};
  assign gmask   = (HPA_W'(1) << gshift) - HPA_W'(1);
  assign block   = offset >> gshift;
  assign wmask   = SLOT_W'((4'd1 << ways_enc_i) - 4'd1);
  assign slot    = block[SLOT_W-1:0] & wmask;
  assign row     = block >> ways_enc_i;
  assign dev_off = (row << gshift) | (offset & gmask);
  assign tgt_o   = tgt_list_i[slot];
  assign dpa_o   = dpa_base_i + DPA_W'(dev_off);

  assign span    = size_i >> ways_enc_i;
  assign dpa_end = {1'b0, dpa_base_i} + (DPA_W+1)'(span);

  always_comb begin
    if (!committed_i)                     mode_o = MODE_NONE;
    else if (dpa_end <= VCAP)             mode_o = MODE_VOL;
    else if ({1'b0, dpa_base_i} >= VCAP)  mode_o = MODE_PERS;
    else                                  mode_o = MODE_MIXED;
  end
endmodule

// File: rtl/interleave_decode_bank.sv
module interleave_decode_bank
  import ild_pkg::*;
#(
  parameter int unsigned NUM_DEC = 4,
  parameter int unsigned HPA_W   = 32,
  parameter int unsigned DPA_W   = 32,
  parameter int unsigned TGT_W   = 4,
  parameter int unsigned DATA_W  = 32,
  parameter logic [63:0] VOL_CAP = 64'h4000_0000,
  localparam int unsigned IDX_W  = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [3:0]        wr_field_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              commit_ack_o,
  output logic              commit_err_o,
  input  logic [IDX_W-1:0]  mode_sel_i,
  output logic [1:0]        mode_o,
  input  logic              lk_valid_i,
  input  logic [HPA_W-1:0]  lk_addr_i,
  output logic              lk_valid_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  dec_o,
  output logic [TGT_W-1:0]  tgt_o,
  output logic [DPA_W-1:0]  dpa_o
);
  logic [HPA_W-1:0]               base     [NUM_DEC];
  logic [HPA_W-1:0]               size     [NUM_DEC];
  logic [DPA_W-1:0]               dpa_base [NUM_DEC];
  logic [2:0]                     ways_enc [NUM_DEC];
  logic [2:0]                     gran_enc [NUM_DEC];
  logic [MAX_WAYS-1:0][TGT_W-1:0] tgt_list [NUM_DEC];
  logic [TGT_W-1:0]               m_tgt    [NUM_DEC];
  logic [DPA_W-1:0]               m_dpa    [NUM_DEC];
  mode_e                          m_mode   [NUM_DEC];
  logic [NUM_DEC-1:0]             match, committed, locked;

  logic cmd_commit, cmd_lock, enc_ok;
  assign cmd_commit = wr_en_i && (wr_field_i == F_COMMIT);
  assign cmd_lock   = wr_en_i && (wr_field_i == F_LOCK);
  assign enc_ok     = ways_code_ok(ways_enc[wr_idx_i]) && gran_code_ok(gran_enc[wr_idx_i]);

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
    idb_cfg_regs #(
      .HPA_W(HPA_W), .DPA_W(DPA_W), .TGT_W(TGT_W), .DATA_W(DATA_W)
    ) u_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (wr_en_i && (wr_idx_i == IDX_W'(g))),
      .field_i    (wr_field_i),
      .data_i     (wr_data_i),
      .frozen_i   (committed[g]),
      .base_o     (base[g]),
      .size_o     (size[g]),
      .dpa_base_o (dpa_base[g]),
      .ways_enc_o (ways_enc[g]),
      .gran_enc_o (gran_enc[g]),
      .tgt_list_o (tgt_list[g])
    );

    idb_window_match #(
      .HPA_W(HPA_W), .DPA_W(DPA_W), .TGT_W(TGT_W), .VOL_CAP(VOL_CAP)
    ) u_match (
      .addr_i      (lk_addr_i),
      .committed_i (committed[g]),
      .base_i      (base[g]),
      .size_i      (size[g]),
      .dpa_base_i  (dpa_base[g]),
      .ways_enc_i  (ways_enc[g]),
      .gran_enc_i  (gran_enc[g]),
      .tgt_list_i  (tgt_list[g]),
      .match_o     (match[g]),
      .tgt_o       (m_tgt[g]),
      .dpa_o       (m_dpa[g]),
      .mode_o      (m_mode[g])
    );
  end

  idb_commit_ctrl #(.NUM_DEC(NUM_DEC)) u_commit (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_commit_i (cmd_commit),
    .cmd_lock_i   (cmd_lock),
    .cmd_set_i    (wr_data_i[0]),
    .cmd_idx_i    (wr_idx_i),
    .enc_ok_i     (enc_ok),
    .committed_o  (committed),
    .locked_o     (locked),
    .ack_o        (commit_ack_o),
    .err_o        (commit_err_o)
  );

  assign mode_o = m_mode[mode_sel_i];

  // lowest index wins
  logic             found;
  logic [IDX_W-1:0] sel;
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NUM_DEC - 1; i >= 0; i--) begin
      if (match[i]) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o <= 1'b0;
      hit_o      <= 1'b0;
      dec_o      <= '0;
      tgt_o      <= '0;
      dpa_o      <= '0;
    end else begin
      lk_valid_o <= lk_valid_i;
      hit_o      <= lk_valid_i && found;
      dec_o      <= found ? sel : '0;
      tgt_o      <= found ? m_tgt[sel] : '0;
      dpa_o      <= found ? m_dpa[sel] : '0;
    end
  end

  assert_hit_follows_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(lk_valid_i));
  assert_hit_committed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (($past(committed) & (NUM_DEC'(1) << dec_o)) != '0));
  assert_locked_not_released_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(locked) & ~committed) == '0);
endmodule

// File: tb/interleave_decode_bank_test.sv
module interleave_decode_bank_test;
  localparam int FB = 0, FS = 1, FD = 2, FW = 3, FG = 4, FT = 5, FC = 6, FL = 7;
  localparam longint unsigned VCAP = 64'h4000_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_idx_i = '0;
  logic [3:0]  wr_field_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        commit_ack_o, commit_err_o;
  logic [1:0]  mode_sel_i = '0;
  logic [1:0]  mode_o;
  logic        lk_valid_i = 1'b0;
  logic [31:0] lk_addr_i = '0;
  logic        lk_valid_o, hit_o;
  logic [1:0]  dec_o;
  logic [3:0]  tgt_o;
  logic [31:0] dpa_o;

  interleave_decode_bank uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
    .wr_field_i(wr_field_i), .wr_data_i(wr_data_i), .commit_ack_o(commit_ack_o),
    .commit_err_o(commit_err_o), .mode_sel_i(mode_sel_i), .mode_o(mode_o),
    .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i), .lk_valid_o(lk_valid_o),
    .hit_o(hit_o), .dec_o(dec_o), .tgt_o(tgt_o), .dpa_o(dpa_o)
  );

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  longint unsigned m_base[4], m_size[4], m_dpa[4];
  int m_wenc[4], m_genc[4], m_cnt;
  int m_tg[4][8];
  logic last_ack, last_err;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mirror();
    m_cnt = 0;
    for (int d = 0; d < 4; d++) begin
      m_base[d] = 0; m_size[d] = 0; m_dpa[d] = 0; m_wenc[d] = 0; m_genc[d] = 0;
      for (int s = 0; s < 8; s++) m_tg[d][s] = 0;
    end
  endtask

  task automatic wr(int idx, int fld, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 2'(idx); wr_field_i = 4'(fld); wr_data_i = d;
    @(negedge clk_i);
    last_ack = commit_ack_o; last_err = commit_err_o;
    wr_en_i = 1'b0;
  endtask

  // field write; mirror follows only uncommitted decoders (R9)
  task automatic cfg(int idx, int fld, logic [31:0] d);
    wr(idx, fld, d);
    if (idx >= m_cnt) begin
      case (fld)
        FB: m_base[idx] = d;
        FS: m_size[idx] = d;
        FD: m_dpa[idx]  = d;
        FW: m_wenc[idx] = int'(d[2:0]);
        FG: m_genc[idx] = int'(d[2:0]);
        FT: m_tg[idx][d[18:16]] = int'(d[3:0]);
        default: ;
      endcase
    end
  endtask

  task automatic commit(int idx, int set, bit exp_ok, string tag);
    wr(idx, FC, 32'(set));
    chk({tag, " ack"}, 64'(last_ack), 64'(exp_ok));
    chk({tag, " err"}, 64'(last_err), 64'(!exp_ok));
    if (exp_ok) m_cnt = set ? m_cnt + 1 : m_cnt - 1;
  endtask

  task automatic check_lookup(longint unsigned addr);
    bit exp_hit = 0;
    int exp_dec = 0, exp_tgt = 0;
    longint unsigned exp_dpa = 0;
    for (int d = m_cnt - 1; d >= 0; d--) begin
      if (addr >= m_base[d] && (addr - m_base[d]) < m_size[d]) begin
        longint unsigned off = addr - m_base[d];
        longint unsigned g = 64'd256 << m_genc[d];
        longint unsigned w = 64'd1 << m_wenc[d];
        longint unsigned blk = off / g;
        exp_hit = 1; exp_dec = d;
        exp_tgt = m_tg[d][blk % w];
        exp_dpa = m_dpa[d] + (blk / w) * g + off % g;
      end
    end
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_addr_i = 32'(addr);
    @(negedge clk_i);
    lk_valid_i = 1'b0;
    chk("R6 valid", 64'(lk_valid_o), 64'd1);
    chk("R2 hit", 64'(hit_o), 64'(exp_hit));
    if (exp_hit) begin
      chk("R5 dec", 64'(dec_o), 64'(exp_dec));
      chk("R3 tgt", 64'(tgt_o), 64'(exp_tgt));
      chk("R4 dpa", 64'(dpa_o), 64'(32'(exp_dpa)));
    end
  endtask

  task automatic check_mode(int sel, int exp, string tag);
    @(negedge clk_i);
    mode_sel_i = 2'(sel);
    #1;
    chk(tag, 64'(mode_o), 64'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    clear_mirror();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL R6 watchdog actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin
    clear_mirror();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 ack", 64'(commit_ack_o), 64'd0);
    chk("R1 err", 64'(commit_err_o), 64'd0);
    chk("R1 hit", 64'(hit_o), 64'd0);
    for (int s = 0; s < 4; s++) check_mode(s, 0, "R1 mode");
    check_lookup(64'h0);
    @(negedge clk_i);
    chk("R6 idle valid", 64'(lk_valid_o), 64'd0);

    // R8 illegal encodings
    for (int s = 0; s < 8; s++) cfg(0, FT, 32'((s << 16) | ((s * 5 + 3) & 15)));
    cfg(0, FW, 32'd5);
    commit(0, 1, 0, "R8 ways");
    cfg(0, FW, 32'd2); cfg(0, FG, 32'd7);
    commit(0, 1, 0, "R8 gran");

    // sweep every legal ways/granularity pair
    for (int we = 0; we < 4; we++) begin
      for (int ge = 0; ge < 7; ge++) begin
        longint unsigned g = 64'd256 << ge;
        longint unsigned w = 64'd1 << we;
        longint unsigned b = 64'h2000_0000;
        longint unsigned sz = w * g * 6 + g + g / 2;
        longint unsigned step = ((sz + 2 * g) / 61) | 1;
        cfg(0, FB, 32'(b)); cfg(0, FS, 32'(sz));
        cfg(0, FD, 32'(64'h1000 + ge * 16));
        cfg(0, FW, 32'(we)); cfg(0, FG, 32'(ge));
        commit(0, 1, 1, "R7 commit");
        for (longint unsigned a = b - g; a < b + sz + g; a += step) check_lookup(a);
        check_lookup(b - 1); check_lookup(b);
        check_lookup(b + sz - 1); check_lookup(b + sz);
        commit(0, 0, 1, "R11 release");
      end
    end

    // multi-decoder setup
    cfg(0, FB, 32'h1000_0000); cfg(0, FS, 32'h4000); cfg(0, FW, 32'd1);
    cfg(0, FG, 32'd0); cfg(0, FD, 32'h0);
    cfg(1, FB, 32'h1000_2000); cfg(1, FS, 32'h8000); cfg(1, FW, 32'd0);
    cfg(1, FG, 32'd2); cfg(1, FD, 32'h4000_0000); cfg(1, FT, 32'd7);
    cfg(2, FB, 32'h3000_0000); cfg(2, FS, 32'h1_0000); cfg(2, FW, 32'd0);
    cfg(2, FG, 32'd0); cfg(2, FD, 32'h3FFF_F000); cfg(2, FT, 32'd9);

    commit(1, 1, 0, "R7 out of order");
    commit(2, 1, 0, "R7 out of order");
    check_lookup(64'h1000_5000);
    commit(0, 1, 1, "R7 commit");
    commit(1, 1, 1, "R7 commit");

    // R9 frozen write
    cfg(1, FB, 32'h5000_0000);
    check_lookup(64'h1000_5000);
    check_lookup(64'h5000_0000);

    // R5 overlap
    check_lookup(64'h1000_3000);
    check_lookup(64'h1000_3FFF);
    check_lookup(64'h1000_4000);

    // R11 release order
    commit(0, 0, 0, "R11 not last");
    commit(2, 1, 1, "R7 commit");

    // R12 modes
    check_mode(0, 1, "R12 volatile");
    check_mode(1, 2, "R12 persistent");
    check_mode(2, 3, "R12 mixed");
    check_mode(3, 0, "R12 none");

    // R10 lock
    wr(3, FL, 32'd1);
    commit(3, 1, 1, "R10 lock ignored commit");
    commit(3, 0, 1, "R10 lock ignored release");
    wr(2, FL, 32'd1);
    commit(2, 0, 0, "R10 locked release");
    check_lookup(64'h3000_0100);
    check_mode(2, 3, "R10 mode kept");

    // reset clears everything
    do_reset();
    check_lookup(64'h3000_0100);
    check_mode(2, 0, "R1 mode after reset");
    commit(0, 1, 1, "R1 commit after reset");

    report();
    $finish;
  end
endmodule